// File: doc/BRIEF.md
# Shared-Multiplier Two-Stream Product Engine

This block forms two independent signed products, one per operand stream, with a single multiplier pipeline that runs at twice the stream rate. Each stream presents one operand pair per slow period and holds it for two fast cycles. A registered phase bit, toggling on every fast cycle, steers a 2:1 mux that feeds the pipeline stream 0 in one cycle and stream 1 in the next. Both streams therefore share one multiplier.

At the far end the products are split back into two parallel outputs. The stream 0 product is taken one fast cycle before the stream 1 product, so it passes through one extra holding register. Both outputs then load together and stay stable for two fast cycles. A strobe marks each load. The whole block runs on one fast clock. The slow period is defined only by the phase bit. A period starts in a cycle where the phase is 0, and the first cycle after reset has phase 0.

Number the fast cycles after reset release from 0. The pair presented in cycles 2n and 2n+1 produces a result on both outputs from cycle 2n+5, and the result holds through cycle 2n+6. The stream 1 path has four registers: two input stages, one after the multiplier and the output register. The stream 0 path has five.

Top module: `dual_stream_mult`

## Requirements
- R1: `prod0` equals `op_a0 * op_b0`, with both operands 18-bit two's complement and the result the full 36-bit two's complement product.
- R2: Stream 0 operands are sampled only in phase-0 cycles (even cycles after reset) and stream 1 operands only in phase-1 cycles (odd cycles). A change of `op_a0`/`op_b0` in a phase-1 cycle has no effect on any result, and neither does a change of `op_a1`/`op_b1` in a phase-0 cycle.
- R3: The internal phase is 0 in the first cycle after reset and inverts on every fast cycle. A reset applied in the middle of a run restarts the numbering, so the first pair after release is again taken by stream 0 in cycle 0.
- R4: The pair presented in cycles 2n and 2n+1 appears on `prod0`/`prod1` at the start of cycle 2n+5. Neither output shows it earlier.
- R5: `res_stb` is high in cycle 2n+5 for every n >= 0 and low in every other cycle. It is never high in two consecutive cycles, and it is high only in phase-1 cycles.
- R6: `prod0` and `prod1` change only in cycles where `res_stb` is high. Each result holds for two fast cycles.
- R7: While `rst` is high, and after release until the first strobe, `prod0`, `prod1` and `res_stb` are 0.
- R8: `prod1` equals `op_a1 * op_b1` (signed, 36 bits), independent of stream 0 operands, with no crosstalk between the streams.
- R9: Extreme operands give exact products, for example -131072 * -131072 = 17179869184 and -131072 * 131071.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, twice the operand rate |
| rst | input | 1 | Synchronous active-high reset |
| op_a0 | input | 18 | Stream 0 first operand, signed |
| op_b0 | input | 18 | Stream 0 second operand, signed |
| op_a1 | input | 18 | Stream 1 first operand, signed |
| op_b1 | input | 18 | Stream 1 second operand, signed |
| prod0 | output | 36 | Stream 0 product, signed, registered |
| prod1 | output | 36 | Stream 1 product, signed, registered |
| res_stb | output | 1 | High in the cycle both products load |

## Verification
The first sweep crosses eight corner operands for stream 0 (full negative, full positive, ±1, 0, 2 and two midrange values) in all 64 combinations. Stream 1 gets a permuted combination of the same set in each period, so a swapped or shared result shows up as a mismatch on one of the outputs. A long pseudo-random run then separates a correct sign extension and product width from a truncated one.

A second run after a mid-stream reset drives garbage onto each stream's operands in the other stream's slot. This tells a correct mux select and phase from an inverted or late one. It also shows whether the pipeline restarts with stream 0.

Every cycle's output is compared against the period the fixed latency predicts. This catches a pipeline that is one stage too short or too long, and a stream 0 result that skipped its realignment register.

// File: rtl/dsm_pkg.sv
package dsm_pkg;

    // Which stream occupies the shared pipeline in a given fast cycle.
    typedef enum logic {
        SLOT_S0 = 1'b0,
        SLOT_S1 = 1'b1
    } slot_e;

endpackage

// File: rtl/dsm_phase.sv
module dsm_phase
    import dsm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    output slot_e slot_o
);

    typedef struct packed {
        slot_e slot;
    } phase_t;

    phase_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.slot = (st_q.slot == SLOT_S0) ? SLOT_S1 : SLOT_S0;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign slot_o = st_q.slot;

    // R3: phase inverts every fast cycle
    a_r3_phase_toggles: assert property (@(posedge clk) disable iff (rst)
        (st_q.slot == SLOT_S0) |=> (st_q.slot == SLOT_S1));
    a_r3_phase_toggles_back: assert property (@(posedge clk) disable iff (rst)
        (st_q.slot == SLOT_S1) |=> (st_q.slot == SLOT_S0));
    // R3: first cycle after reset selects stream 0
    a_r3_starts_stream0: assert property (@(posedge clk)
        $past(rst) |-> (st_q.slot == SLOT_S0));

endmodule

// File: rtl/dsm_operand_pipe.sv
module dsm_operand_pipe
    import dsm_pkg::*;
#(
    parameter int OP_W = 18
) (
    input  logic            clk,
    input  logic            rst,
    input  slot_e           slot_i,
    input  logic [OP_W-1:0] a0_i,
    input  logic [OP_W-1:0] b0_i,
    input  logic [OP_W-1:0] a1_i,
    input  logic [OP_W-1:0] b1_i,
    output logic [OP_W-1:0] a_o,
    output logic [OP_W-1:0] b_o,
    output logic            vld_o,
    output slot_e           slot_o
);

    typedef struct packed {
        logic [OP_W-1:0] a;
        logic [OP_W-1:0] b;
        logic            vld;
        slot_e           slot;
    } opnd_t;

    typedef struct packed {
        opnd_t s1;   // mux capture stage
        opnd_t s2;   // second input stage
    } pipe_t;

    pipe_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        // single 2:1 mux level in front of the first register
        st_d.s1.a    = (slot_i == SLOT_S0) ? a0_i : a1_i;
        st_d.s1.b    = (slot_i == SLOT_S0) ? b0_i : b1_i;
        st_d.s1.vld  = 1'b1;
        st_d.s1.slot = slot_i;
        st_d.s2      = st_q.s1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign a_o    = st_q.s2.a;
    assign b_o    = st_q.s2.b;
    assign vld_o  = st_q.s2.vld;
    assign slot_o = st_q.s2.slot;

    // R2: the two input stages carry opposite slots once filled
    a_r2_slots_interleave: assert property (@(posedge clk) disable iff (rst)
        (st_q.s1.vld && st_q.s2.vld) |-> (st_q.s1.slot != st_q.s2.slot));

endmodule

// File: rtl/dsm_mult.sv
module dsm_mult
    import dsm_pkg::*;
#(
    parameter int OP_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [OP_W-1:0]   a_i,
    input  logic [OP_W-1:0]   b_i,
    input  logic              vld_i,
    input  slot_e             slot_i,
    output logic [2*OP_W-1:0] p_o,
    output logic              vld_o,
    output slot_e             slot_o
);

    localparam int PR_W = 2 * OP_W;

    typedef struct packed {
        logic [PR_W-1:0] p;
        logic            vld;
        slot_e           slot;
    } mul_t;

    mul_t st_d, st_q;
    logic signed [PR_W-1:0] a_ext, b_ext;

    always_comb begin
        a_ext      = PR_W'($signed(a_i));
        b_ext      = PR_W'($signed(b_i));
        st_d       = st_q;
        st_d.p     = a_ext * b_ext;
        st_d.vld   = vld_i;
        st_d.slot  = slot_i;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign p_o    = st_q.p;
    assign vld_o  = st_q.vld;
    assign slot_o = st_q.slot;

endmodule

// File: rtl/dsm_realign.sv
module dsm_realign
    import dsm_pkg::*;
#(
    parameter int PR_W = 36
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PR_W-1:0] p_i,
    input  logic            vld_i,
    input  slot_e           slot_i,
    output logic [PR_W-1:0] out0_o,
    output logic [PR_W-1:0] out1_o,
    output logic            stb_o
);

    typedef struct packed {
        logic [PR_W-1:0] hold0;  // extra stage for the earlier stream
        logic [PR_W-1:0] out0;
        logic [PR_W-1:0] out1;
        logic            stb;
    } algn_t;

    algn_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.stb = 1'b0;
        if (vld_i && slot_i == SLOT_S0) begin
            st_d.hold0 = p_i;
        end
        if (vld_i && slot_i == SLOT_S1) begin
            st_d.out0 = st_q.hold0;
            st_d.out1 = p_i;
            st_d.stb  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out0_o = st_q.out0;
    assign out1_o = st_q.out1;
    assign stb_o  = st_q.stb;

    // R5: strobe never on two consecutive cycles
    a_r5_strobe_isolated: assert property (@(posedge clk) disable iff (rst)
        st_q.stb |=> !st_q.stb);
    // R6: outputs hold between strobes
    a_r6_outputs_hold: assert property (@(posedge clk) disable iff (rst)
        !st_q.stb |-> ($stable(st_q.out0) && $stable(st_q.out1)));

endmodule

// File: rtl/dual_stream_mult.sv
module dual_stream_mult
    import dsm_pkg::*;
#(
    parameter int OP_W = 18,
    localparam int PR_W = 2 * OP_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] op_a0,
    input  logic [OP_W-1:0] op_b0,
    input  logic [OP_W-1:0] op_a1,
    input  logic [OP_W-1:0] op_b1,
    output logic [PR_W-1:0] prod0,
    output logic [PR_W-1:0] prod1,
    output logic            res_stb
);

    slot_e           phase_q;
    logic [OP_W-1:0] opa_q, opb_q;
    logic            opv_q;
    slot_e           ops_q;
    logic [PR_W-1:0] mp_q;
    logic            mv_q;
    slot_e           ms_q;

    dsm_phase u_phase (
        .clk    (clk),
        .rst    (rst),
        .slot_o (phase_q)
    );

    dsm_operand_pipe #(.OP_W(OP_W)) u_opnd (
        .clk    (clk),
        .rst    (rst),
        .slot_i (phase_q),
        .a0_i   (op_a0),
        .b0_i   (op_b0),
        .a1_i   (op_a1),
        .b1_i   (op_b1),
        .a_o    (opa_q),
        .b_o    (opb_q),
        .vld_o  (opv_q),
        .slot_o (ops_q)
    );

    dsm_mult #(.OP_W(OP_W)) u_mult (
        .clk    (clk),
        .rst    (rst),
        .a_i    (opa_q),
        .b_i    (opb_q),
        .vld_i  (opv_q),
        .slot_i (ops_q),
        .p_o    (mp_q),
        .vld_o  (mv_q),
        .slot_o (ms_q)
    );

    dsm_realign #(.PR_W(PR_W)) u_algn (
        .clk    (clk),
        .rst    (rst),
        .p_i    (mp_q),
        .vld_i  (mv_q),
        .slot_i (ms_q),
        .out0_o (prod0),
        .out1_o (prod1),
        .stb_o  (res_stb)
    );

    // R5: results land only in phase-1 cycles
    a_r5_strobe_phase: assert property (@(posedge clk) disable iff (rst)
        res_stb |-> (phase_q == SLOT_S1));
    // R7: nothing reported while the multiplier stage has no stream 1 data
    a_r7_quiet_until_valid: assert property (@(posedge clk) disable iff (rst)
        !$past(mv_q) |-> !res_stb);

endmodule

// File: tb/test_dual_stream_mult.sv
module test_dual_stream_mult;

    localparam int OP_W = 18;
    localparam int PR_W = 2 * OP_W;
    localparam int MAXP = 512;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [OP_W-1:0] op_a0 = '0, op_b0 = '0, op_a1 = '0, op_b1 = '0;
    logic [PR_W-1:0] prod0, prod1;
    logic            res_stb;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [OP_W-1:0] pa0 [MAXP], pb0 [MAXP], pa1 [MAXP], pb1 [MAXP];
    logic [OP_W-1:0] corner [8];
    logic [OP_W-1:0] lfsr = 18'h2B5E1;

    always #5 clk = ~clk;

    dual_stream_mult #(.OP_W(OP_W)) i_dual_stream_mult (
        .clk     (clk),
        .rst     (rst),
        .op_a0   (op_a0),
        .op_b0   (op_b0),
        .op_a1   (op_a1),
        .op_b1   (op_b1),
        .prod0   (prod0),
        .prod1   (prod1),
        .res_stb (res_stb)
    );

    function automatic logic [PR_W-1:0] mul(input logic [OP_W-1:0] a, input logic [OP_W-1:0] b);
        longint sa, sb, r;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        r  = sa * sb;
        return r[PR_W-1:0];
    endfunction

    function automatic logic [OP_W-1:0] next_rand();
        lfsr = {lfsr[OP_W-2:0], lfsr[17] ^ lfsr[10]};
        return lfsr ^ {lfsr[8:0], lfsr[17:9]};
    endfunction

    task automatic chk(input string tag, input logic [PR_W-1:0] act, input logic [PR_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R7 prod0 in reset", prod0, '0);
        chk("R7 prod1 in reset", prod1, '0);
        chk("R7 strobe in reset", PR_W'(res_stb), '0);
        rst = 1'b0;   // current cycle is cycle 0
    endtask

    // skew=1: each stream's operands are overwritten with garbage in the other stream's slot
    task automatic run(input int nper, input bit skew, input bit second);
        for (int k = 0; k < 2 * nper + 5; k++) begin
            int m;
            if (k > 0) @(negedge clk);
            // checks on registered outputs
            m = (k - 5) >>> 1;
            if (k < 5) begin
                chk("R7 prod0 before first strobe", prod0, '0);
                chk("R7 prod1 before first strobe", prod1, '0);
                chk(second ? "R3 strobe low after reset" : "R7 strobe low", PR_W'(res_stb), '0);
            end else if (k % 2 == 1) begin
                chk(second ? "R3 strobe on update after re-reset" : "R5 strobe on update",
                    PR_W'(res_stb), PR_W'(1));
                if (k == 5)
                    chk("R4 first result latency", prod0, mul(pa0[m], pb0[m]));
                else if (skew)
                    chk("R2 prod0 ignores off-slot change", prod0, mul(pa0[m], pb0[m]));
                else if (m < 64)
                    chk("R9 prod0 corner", prod0, mul(pa0[m], pb0[m]));
                else
                    chk("R1 prod0", prod0, mul(pa0[m], pb0[m]));
                chk(skew ? "R2 prod1 ignores off-slot change" : "R8 prod1", prod1, mul(pa1[m], pb1[m]));
            end else begin
                chk("R5 strobe low between updates", PR_W'(res_stb), '0);
                chk("R6 prod0 held", prod0, mul(pa0[m], pb0[m]));
                chk("R6 prod1 held", prod1, mul(pa1[m], pb1[m]));
            end
            // drive
            if (k < 2 * nper) begin
                if (k % 2 == 0) begin
                    op_a0 = pa0[k / 2];
                    op_b0 = pb0[k / 2];
                    if (skew) begin
                        op_a1 = next_rand();
                        op_b1 = next_rand();
                    end else begin
                        op_a1 = pa1[k / 2];
                        op_b1 = pb1[k / 2];
                    end
                end else begin
                    op_a1 = pa1[k / 2];
                    op_b1 = pb1[k / 2];
                    if (skew) begin
                        op_a0 = next_rand();
                        op_b0 = next_rand();
                    end
                end
            end
        end
    endtask

    initial begin
        corner[0] = 18'h20000;  // -131072
        corner[1] = 18'h1FFFF;  //  131071
        corner[2] = 18'h3FFFF;  // -1
        corner[3] = 18'h00000;
        corner[4] = 18'h00001;
        corner[5] = 18'h00002;
        corner[6] = 18'h2AAAA;
        corner[7] = 18'h15555;

        // run 1: 64 corner periods then random
        for (int n = 0; n < 64; n++) begin
            pa0[n] = corner[n / 8];
            pb0[n] = corner[n % 8];
            pa1[n] = corner[7 - (n % 8)];
            pb1[n] = corner[(n / 8 + 3) % 8];
        end
        for (int n = 64; n < 264; n++) begin
            pa0[n] = next_rand();
            pb0[n] = next_rand();
            pa1[n] = next_rand();
            pb1[n] = next_rand();
        end
        do_reset();
        run(264, 1'b0, 1'b0);

        // run 2: mid-run reset, off-slot garbage on both streams
        for (int n = 0; n < 40; n++) begin
            pa0[n] = next_rand();
            pb0[n] = next_rand();
            pa1[n] = next_rand();
            pb1[n] = next_rand();
        end
        @(negedge clk);
        do_reset();
        run(40, 1'b1, 1'b1);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule